// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block receives 8-bit characters from an asynchronous serial line. A one-cycle enable pulse, running at sixteen times the bit rate, paces all sampling. The line first passes through a synchronizer and then an optional glitch filter. A small state machine finds the start bit, confirms it at its centre, and samples each later bit at its centre. When the stop bit has been sampled, the received byte is presented together with a ready flag.

Two sticky error flags report a stop bit read as 0 and a parity bit that does not match the selected parity. Both flags set in the same clock as ready and stay high until a status-clear pulse is applied. Ready drops on a read strobe. Bit-rate generation, buffering and software access belong to the surrounding logic.

Top module: `async_rx`

## Requirements
- R1: While reset is held and directly after it, rxData is 0 and rxReady, frameErr and parErr are low.
- R2: A frame is a low start bit, 8 data bits least significant first, an optional parity bit, then a stop bit. Each bit lasts 16 ticks. After the stop bit is sampled, rxData holds the byte and rxReady is high.
- R3: A low level seen on a tick while the receiver is armed and idle starts a frame. The start bit is checked again 8 ticks later, and each later bit is sampled 16 ticks after the previous one. If the start check reads high, the receiver returns to idle and rxReady is not raised.
- R4: parMode selects the parity bit: 0 none, 1 even (the bit makes the count of ones in data plus parity even), 2 odd, 3 fixed 0, 4 fixed 1. Values 5 to 7 mean none.
- R5: If a parity bit is enabled and does not match the selected parity, parErr rises in the same clock as rxReady. It then stays high across later good frames.
- R6: If the stop bit is sampled as 0, frameErr rises in the same clock as rxReady, and the byte is still delivered. It then stays high across later good frames.
- R7: A one-clock clrSts pulse clears frameErr and parErr. If a frame completes in the same clock, the new error is kept.
- R8: A one-clock rdStb pulse clears rxReady. A frame that completes while rxReady is still high replaces rxData.
- R9: With filterOn low, the receiver uses only the most recent tick sample. A one-tick inversion at the centre of a bit therefore corrupts that bit.
- R10: With filterOn high, the receiver uses the majority of the last three tick samples. A one-tick inversion anywhere in a bit is rejected, and so is an isolated one-tick low pulse on an idle line.
- R11: After each frame, the receiver needs the line to be high on at least one tick before it accepts a new start. A line held low after a framing error therefore starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable pulse at 16x the bit rate |
| rxLine | input | 1 | Serial receive line, idle high |
| filterOn | input | 1 | Enables the 2-of-3 majority filter |
| parMode | input | 3 | Parity selection (encoding in R4) |
| rdStb | input | 1 | Read strobe, clears rxReady |
| clrSts | input | 1 | Status-clear pulse for both error flags |
| rxData | output | 8 | Last received byte |
| rxReady | output | 1 | A byte is waiting to be read |
| frameErr | output | 1 | Sticky stop-bit error |
| parErr | output | 1 | Sticky parity error |

## Verification
The line takes two clock cycles to pass the synchronizer and is captured on the next tick. The state machine acts one tick after that, and the filter adds one more tick. A start bit that begins in tick period k is therefore detected on tick k+1 (k+2 when filtered), and every bit is sampled at offset 8 (offsets 7 to 9 when filtered). Ready and the error flags rise one clock after the tick that samples the stop bit, about nine ticks into the stop bit. The bench drives the line one whole tick period at a time, so a value is always stable well before the tick that samples it. It checks data and flags only after the full stop-bit period has elapsed, and checks cleared flags one clock after the strobe. The centre-of-bit glitch tests rely on this fixed sampling offset.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic parCap;
    logic done;
  } rxStrobe_t;

  localparam logic [2:0] PAR_NONE  = 3'd0;
  localparam logic [2:0] PAR_EVEN  = 3'd1;
  localparam logic [2:0] PAR_ODD   = 3'd2;
  localparam logic [2:0] PAR_SPACE = 3'd3;
  localparam logic [2:0] PAR_MARK  = 3'd4;

  function automatic logic parityEnabled(input logic [2:0] mode);
    return (mode >= PAR_EVEN) && (mode <= PAR_MARK);
  endfunction

endpackage

// File: rtl/async_rx_ctrl.sv
module async_rx_ctrl
  import async_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       lineVal,
  input  logic [2:0] parMode,
  output rxStrobe_t  strobes
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rxState_t         stateQ;
  logic [CNT_W-1:0] cntQ;
  logic [IDX_W-1:0] bitIdxQ;
  logic             armedQ;
  logic             parOn;

  assign parOn = parityEnabled(parMode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= RX_IDLE;
      cntQ    <= '0;
      bitIdxQ <= '0;
      armedQ  <= 1'b0;
    end else if (tick) begin
      case (stateQ)
        RX_IDLE: begin
          if (armedQ && !lineVal) begin
            stateQ <= RX_START;
            cntQ   <= '0;
            armedQ <= 1'b0;
          end else if (lineVal) begin
            armedQ <= 1'b1;
          end
        end
        RX_START: begin
          if (cntQ == MID_CNT) begin
            cntQ <= '0;
            if (!lineVal) begin
              stateQ  <= RX_DATA;
              bitIdxQ <= '0;
            end else begin
              stateQ <= RX_IDLE;
            end
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        RX_DATA: begin
          if (cntQ == LAST_CNT) begin
            cntQ    <= '0;
            bitIdxQ <= bitIdxQ + 1'b1;
            if (bitIdxQ == LAST_IDX) stateQ <= parOn ? RX_PAR : RX_STOP;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        RX_PAR: begin
          if (cntQ == LAST_CNT) begin
            cntQ   <= '0;
            stateQ <= RX_STOP;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        RX_STOP: begin
          if (cntQ == LAST_CNT) begin
            cntQ   <= '0;
            stateQ <= RX_IDLE;
            armedQ <= 1'b0;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        default: stateQ <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.shiftEn = tick && (stateQ == RX_DATA) && (cntQ == LAST_CNT);
    strobes.parCap  = tick && (stateQ == RX_PAR)  && (cntQ == LAST_CNT);
    strobes.done    = tick && (stateQ == RX_STOP) && (cntQ == LAST_CNT);
  end

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.shiftEn, strobes.parCap, strobes.done}));

  // R11
  rearm_after_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done |=> (stateQ == RX_IDLE) && !armedQ);

  // R3
  false_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == RX_START && tick && cntQ == MID_CNT && lineVal) |=> stateQ == RX_IDLE);

endmodule

// File: rtl/async_rx_dp.sv
module async_rx_dp
  import async_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              rxLine,
  input  logic              filterOn,
  input  logic [2:0]        parMode,
  input  logic              rdStb,
  input  logic              clrSts,
  input  rxStrobe_t         strobes,
  output logic              lineVal,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              frameErr,
  output logic              parErr
);

  localparam int MAJ_MIN = FILT_TAPS/2 + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [FILT_TAPS-1:0]   sampQ;
  logic [DATA_W-1:0]      shiftQ;
  logic                   parBitQ;
  logic                   majVal;
  logic                   expPar;
  logic                   parBad;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= rxLine;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     sampQ <= '1;
    else if (tick) sampQ <= {sampQ[FILT_TAPS-2:0], syncQ[SYNC_STAGES-1]};
  end

  assign majVal  = ($countones(sampQ) >= MAJ_MIN);
  assign lineVal = filterOn ? majVal : sampQ[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      parBitQ <= 1'b0;
    end else begin
      if (strobes.shiftEn) shiftQ  <= {lineVal, shiftQ[DATA_W-1:1]};
      if (strobes.parCap)  parBitQ <= lineVal;
    end
  end

  always_comb begin
    case (parMode)
      PAR_EVEN:  expPar = ^shiftQ;
      PAR_ODD:   expPar = ~^shiftQ;
      PAR_SPACE: expPar = 1'b0;
      PAR_MARK:  expPar = 1'b1;
      default:   expPar = 1'b0;
    endcase
    parBad = parityEnabled(parMode) && (parBitQ != expPar);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= '0;
      rxReady  <= 1'b0;
      frameErr <= 1'b0;
      parErr   <= 1'b0;
    end else begin
      if (strobes.done) rxData <= shiftQ;
      rxReady  <= (rxReady  & ~rdStb)  | strobes.done;
      frameErr <= (frameErr & ~clrSts) | (strobes.done & ~lineVal);
      parErr   <= (parErr   & ~clrSts) | (strobes.done & parBad);
    end
  end

  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxReady) |-> $past(rdStb));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(frameErr) || $fell(parErr)) |-> $past(clrSts));

  // R6
  frame_with_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> rxReady);

  // R5
  par_with_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parErr) |-> rxReady);

endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              rxLine,
  input  logic              filterOn,
  input  logic [2:0]        parMode,
  input  logic              rdStb,
  input  logic              clrSts,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              frameErr,
  output logic              parErr
);

  rxStrobe_t strobes;
  logic      lineVal;

  async_rx_ctrl #(
    .DATA_W     (DATA_W),
    .OVERSAMPLE (OVERSAMPLE)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick16),
    .lineVal (lineVal),
    .parMode (parMode),
    .strobes (strobes)
  );

  async_rx_dp #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_TAPS   (FILT_TAPS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick16),
    .rxLine   (rxLine),
    .filterOn (filterOn),
    .parMode  (parMode),
    .rdStb    (rdStb),
    .clrSts   (clrSts),
    .strobes  (strobes),
    .lineVal  (lineVal),
    .rxData   (rxData),
    .rxReady  (rxReady),
    .frameErr (frameErr),
    .parErr   (parErr)
  );

endmodule

// File: tb/async_rx_bench.sv
module async_rx_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxLine = 1'b1;
  logic       filterOn = 1'b0;
  logic [2:0] parMode = 3'd0;
  logic       rdStb = 1'b0;
  logic       clrSts = 1'b0;
  logic [7:0] rxData;
  logic       rxReady;
  logic       frameErr;
  logic       parErr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  async_rx u_async_rx (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxLine(rxLine),
    .filterOn(filterOn), .parMode(parMode), .rdStb(rdStb), .clrSts(clrSts),
    .rxData(rxData), .rxReady(rxReady), .frameErr(frameErr), .parErr(parErr)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic parBit(input logic [7:0] d, input logic [2:0] m);
    case (m)
      3'd1: return ^d;
      3'd2: return ~^d;
      3'd4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit parUsed(input logic [2:0] m);
    return (m >= 3'd1) && (m <= 3'd4);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic period(input logic v);
    @(negedge clk);
    rxLine = v;
    repeat (3) @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  task automatic hold(input logic v, input int n);
    for (int i = 0; i < n; i++) period(v);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic [2:0] m,
                           input bit badPar, input logic stopV, input bit glitch);
    hold(1'b0, 16);
    for (int b = 0; b < 8; b++)
      for (int o = 0; o < 16; o++)
        period((glitch && o == 8) ? ~d[b] : d[b]);
    if (parUsed(m)) hold(parBit(d, m) ^ badPar, 16);
    hold(stopV, 16);
  endtask

  task automatic readOut();
    @(negedge clk); rdStb = 1'b1;
    @(negedge clk); rdStb = 1'b0;
  endtask

  task automatic clearFlags();
    @(negedge clk); clrSts = 1'b1;
    @(negedge clk); clrSts = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h1D5E));
    repeat (3) @(negedge clk);
    check("R1 ready in reset", rxReady, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready", rxReady, 0);
    check("R1 frameErr", frameErr, 0);
    check("R1 parErr", parErr, 0);
    check("R1 data", rxData, 0);

    hold(1'b1, 3);
    sendFrame(8'hA5, 3'd0, 0, 1'b1, 0);
    check("R2 ready", rxReady, 1);
    check("R2 data", rxData, 8'hA5);
    check("R2 no errors", {frameErr, parErr}, 0);
    readOut();
    check("R8 ready cleared", rxReady, 0);

    // R3 unconfirmed start
    hold(1'b0, 4);
    hold(1'b1, 30);
    check("R3 false start no ready", rxReady, 0);
    sendFrame(8'h3C, 3'd0, 0, 1'b1, 0);
    check("R3 frame after false start", rxData, 8'h3C);
    readOut();

    // R4 all parity modes
    for (int m = 1; m <= 4; m++) begin
      parMode = 3'(m);
      sendFrame(8'h6B, 3'(m), 0, 1'b1, 0);
      check("R4 parity mode data", rxData, 8'h6B);
      check("R4 parity mode no parErr", parErr, 0);
      readOut();
    end

    // R5 wrong parity
    parMode = 3'd1;
    sendFrame(8'h6B, 3'd1, 1, 1'b1, 0);
    check("R5 parErr", parErr, 1);
    check("R5 ready with parErr", rxReady, 1);
    readOut();
    parMode = 3'd0;
    sendFrame(8'h0F, 3'd0, 0, 1'b1, 0);
    check("R5 parErr sticky", parErr, 1);
    readOut();
    clearFlags();
    check("R7 parErr cleared", parErr, 0);

    // R6 stop bit low, R11 line held low
    sendFrame(8'h81, 3'd0, 0, 1'b0, 0);
    check("R6 frameErr", frameErr, 1);
    check("R6 ready", rxReady, 1);
    check("R6 data kept", rxData, 8'h81);
    readOut();
    hold(1'b0, 170);
    check("R11 no frame while low", rxReady, 0);
    hold(1'b1, 2);
    sendFrame(8'h5A, 3'd0, 0, 1'b1, 0);
    check("R11 frame after rearm", rxData, 8'h5A);
    check("R6 frameErr sticky", frameErr, 1);
    readOut();
    clearFlags();
    check("R7 frameErr cleared", frameErr, 0);

    // R8 overwrite
    sendFrame(8'h11, 3'd0, 0, 1'b1, 0);
    sendFrame(8'h22, 3'd0, 0, 1'b1, 0);
    check("R8 overwrite data", rxData, 8'h22);
    check("R8 ready still set", rxReady, 1);
    readOut();

    // R9 unfiltered glitch corrupts
    filterOn = 1'b0;
    sendFrame(8'hC3, 3'd0, 0, 1'b1, 1);
    check("R9 unfiltered glitch", rxData, 8'h3C);
    readOut();

    // R10 filtered glitch rejected
    filterOn = 1'b1;
    hold(1'b1, 3);
    sendFrame(8'hC3, 3'd0, 0, 1'b1, 1);
    check("R10 filtered glitch", rxData, 8'hC3);
    readOut();
    hold(1'b0, 1);
    hold(1'b1, 30);
    check("R10 idle pulse rejected", rxReady, 0);

    // random frames
    for (int i = 0; i < 24; i++) begin
      logic [7:0] d;
      logic [2:0] m;
      bit f;
      d = 8'($urandom);
      m = 3'($urandom_range(0, 4));
      f = 1'($urandom);
      filterOn = f;
      parMode = m;
      hold(1'b1, 3);
      sendFrame(d, m, 0, 1'b1, f);
      check("R2 random data", rxData, d);
      check("R4 random parity ok", {frameErr, parErr}, 0);
      readOut();
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule